// File: doc/BRIEF.md
# Bus Cycle Trace Record Encoder

This block observes an on-chip 32-bit bus on every clock edge. For each cycle in which a bus transaction is active, it builds a 64-bit clock-cycle trace record. The record is presented as two 32-bit words that a trace buffer can write to consecutive word addresses. The first word carries a format flag, a wait flag and the word-aligned address. The second word carries either the bus data or a fixed marker value. The markers separate three kinds of non-data cycle: a true wait state, a transfer with every byte lane disabled, and a cycle that reports an undecoded-address error.

The record is registered. It appears one clock after the observed cycle, together with a valid strobe that is high for that single cycle. Idle bus cycles produce no record. The format flag is always driven to the clock-cycle value. The block does not manage the trace buffer and has no trigger logic.

Top module: `bus_trace_encoder`

## Requirements
- R1: Each cycle with `busActive` high gives exactly one record: `recValid` is high in the next cycle and carries that cycle's content.
- R2: A cycle with `busActive` low gives no record: `recValid` is low in the next cycle, whatever the other bus inputs are.
- R3: Bit 31 of `recWord0` (the format flag) is 0 in every record, which marks it as a clock-cycle record.
- R4: Bits 29:0 of `recWord0` equal bits 31:2 of the observed `busAddr`.
- R5: Bit 30 of `recWord0` (the wait flag) is 1 when `busWait` is high or `busByteEn` is 4'b0000, and is 0 otherwise.
- R6: On an active cycle with no wait, at least one enabled byte lane and no error, `recWord1` equals `busData`.
- R7: On a wait cycle without an error, `recWord1` is 32'h00000000. This takes priority over the lane marker.
- R8: On a cycle with no wait, all four byte lanes disabled and no error, `recWord1` is 32'h11111111.
- R9: On an active cycle with `busAddrErr` high, `recWord1` is 32'h22222222, whatever the state of wait and byte lanes.
- R10: While `rstN` is low, and in the first cycle after it rises, `recValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busActive | input | 1 | A bus transaction is active in this cycle |
| busAddr | input | 32 | Bus address |
| busData | input | 32 | Bus data |
| busWait | input | 1 | Wait state in this cycle |
| busByteEn | input | 4 | Byte-lane enables, one bit per lane |
| busAddrErr | input | 1 | Undecoded-address error in this cycle |
| recValid | output | 1 | Record strobe, high for one cycle per record |
| recWord0 | output | 32 | Format flag, wait flag and address[31:2] |
| recWord1 | output | 32 | Data word or marker |

## Verification
A wrong cycle classification inside the block shows up in the very next record. The marker in `recWord1` or the wait flag in `recWord0` is then wrong in the cycle after the stimulus. A stuck or miscounted capture strobe shows up as a missing or extra `recValid` pulse against the one-per-active-cycle expectation, again within one clock. The stimulus mixes wait, zero-lane and error conditions in every combination, so a priority mistake between markers gives a wrong word in the first cycle where the conditions overlap.

// File: rtl/bus_trace_pkg.sv
package bus_trace_pkg;
  typedef enum logic [1:0] {
    CYC_XFER   = 2'd0,
    CYC_WAIT   = 2'd1,
    CYC_NOLANE = 2'd2,
    CYC_ERR    = 2'd3
  } cycKindE;

  typedef struct packed {
    logic    capture;
    logic    waitFlag;
    cycKindE kind;
  } ctrlStrobeS;

  localparam logic FMT_CLOCK_CYCLE = 1'b0;
endpackage

// File: rtl/bus_trace_ctrl.sv
module bus_trace_ctrl
  import bus_trace_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busActive,
  input  logic             busWait,
  input  logic [LANES-1:0] busByteEn,
  input  logic             busAddrErr,
  output ctrlStrobeS       strobe,
  output logic             recValid
);
  logic noLanes;

  assign noLanes = (busByteEn == '0);

  // Classification order: error first, then wait, then empty lanes.
  always_comb begin
    strobe.capture  = busActive;
    strobe.waitFlag = busWait | noLanes;
    if (busAddrErr)   strobe.kind = CYC_ERR;
    else if (busWait) strobe.kind = CYC_WAIT;
    else if (noLanes) strobe.kind = CYC_NOLANE;
    else              strobe.kind = CYC_XFER;
  end

  always_ff @(posedge clk) begin
    if (!rstN) recValid <= 1'b0;
    else       recValid <= busActive;
  end
endmodule

// File: rtl/bus_trace_dp.sv
module bus_trace_dp
  import bus_trace_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeS        strobe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busData,
  output logic [ADDR_W-1:0] recWord0,
  output logic [DATA_W-1:0] recWord1
);
  localparam int BYTES = DATA_W / 8;
  localparam logic [DATA_W-1:0] MARK_WAIT   = '0;
  localparam logic [DATA_W-1:0] MARK_NOLANE = {BYTES{8'h11}};
  localparam logic [DATA_W-1:0] MARK_ERR    = {BYTES{8'h22}};

  logic [ADDR_W-1:0] word0Next;
  logic [DATA_W-1:0] word1Next;

  assign word0Next = {FMT_CLOCK_CYCLE, strobe.waitFlag, busAddr[ADDR_W-1:2]};

  always_comb begin
    unique case (strobe.kind)
      CYC_ERR:    word1Next = MARK_ERR;
      CYC_WAIT:   word1Next = MARK_WAIT;
      CYC_NOLANE: word1Next = MARK_NOLANE;
      default:    word1Next = busData;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      recWord0 <= '0;
      recWord1 <= '0;
    end else if (strobe.capture) begin
      recWord0 <= word0Next;
      recWord1 <= word1Next;
    end
  end
endmodule

// File: rtl/bus_trace_encoder.sv
module bus_trace_encoder
  import bus_trace_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busActive,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busData,
  input  logic                busWait,
  input  logic [DATA_W/8-1:0] busByteEn,
  input  logic                busAddrErr,
  output logic                recValid,
  output logic [ADDR_W-1:0]   recWord0,
  output logic [DATA_W-1:0]   recWord1
);
  localparam int LANES = DATA_W / 8;

  ctrlStrobeS strobe;

  bus_trace_ctrl #(.LANES(LANES)) u_ctrl (
    .clk(clk), .rstN(rstN), .busActive(busActive), .busWait(busWait),
    .busByteEn(busByteEn), .busAddrErr(busAddrErr),
    .strobe(strobe), .recValid(recValid)
  );

  bus_trace_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busAddr(busAddr),
    .busData(busData), .recWord0(recWord0), .recWord1(recWord1)
  );
endmodule

// File: rtl/bus_trace_encoder_sva.sv
module bus_trace_encoder_sva #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic                busActive,
  input logic [ADDR_W-1:0]   busAddr,
  input logic [DATA_W-1:0]   busData,
  input logic                busWait,
  input logic [DATA_W/8-1:0] busByteEn,
  input logic                busAddrErr,
  input logic                recValid,
  input logic [ADDR_W-1:0]   recWord0,
  input logic [DATA_W-1:0]   recWord1
);
  localparam int BYTES = DATA_W / 8;

  AST_RECORD_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN) busActive |=> recValid); // R1
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rstN) !busActive |=> !recValid); // R2
  AST_FORMAT_CLOCK: assert property (@(posedge clk) disable iff (!rstN) recValid |-> !recWord0[ADDR_W-1]); // R3
  AST_ADDR_FIELD: assert property (@(posedge clk) disable iff (!rstN)
    busActive |=> recWord0[ADDR_W-3:0] == $past(busAddr[ADDR_W-1:2])); // R4
  AST_WAIT_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    busActive |=> recWord0[ADDR_W-2] == $past(busWait || (busByteEn == '0))); // R5
  AST_DATA_PASS: assert property (@(posedge clk) disable iff (!rstN)
    busActive && !busWait && !busAddrErr && (busByteEn != '0) |=> recWord1 == $past(busData)); // R6
  AST_WAIT_MARK: assert property (@(posedge clk) disable iff (!rstN)
    busActive && busWait && !busAddrErr |=> recWord1 == '0); // R7
  AST_NOLANE_MARK: assert property (@(posedge clk) disable iff (!rstN)
    busActive && !busWait && !busAddrErr && (busByteEn == '0) |=> recWord1 == {BYTES{8'h11}}); // R8
  AST_ERR_MARK: assert property (@(posedge clk) disable iff (!rstN)
    busActive && busAddrErr |=> recWord1 == {BYTES{8'h22}}); // R9
  AST_RESET_QUIET: assert property (@(posedge clk) !rstN |=> !recValid); // R10
endmodule

bind bus_trace_encoder bus_trace_encoder_sva #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sva (
  .clk(clk), .rstN(rstN), .busActive(busActive), .busAddr(busAddr), .busData(busData),
  .busWait(busWait), .busByteEn(busByteEn), .busAddrErr(busAddrErr),
  .recValid(recValid), .recWord0(recWord0), .recWord1(recWord1)
);

// File: tb/test_bus_trace_encoder.sv
`timescale 1ns/1ps
module test_bus_trace_encoder;
  logic        clk = 1'b0;
  logic        rstN;
  logic        busActive;
  logic [31:0] busAddr;
  logic [31:0] busData;
  logic        busWait;
  logic [3:0]  busByteEn;
  logic        busAddrErr;
  logic        recValid;
  logic [31:0] recWord0;
  logic [31:0] recWord1;

  int checks = 0;
  int failures = 0;
  bit monitorOn = 1'b0;

  logic        expValidQ[$];
  logic [31:0] expW0Q[$];
  logic [31:0] expW1Q[$];
  string       expTagQ[$];

  always #2 clk = ~clk;

  bus_trace_encoder i_bus_trace_encoder (
    .clk(clk), .rstN(rstN), .busActive(busActive), .busAddr(busAddr), .busData(busData),
    .busWait(busWait), .busByteEn(busByteEn), .busAddrErr(busAddrErr),
    .recValid(recValid), .recWord0(recWord0), .recWord1(recWord1)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic act, input logic [31:0] addr, input logic [31:0] data,
                       input logic wt, input logic [3:0] en, input logic err);
    logic [31:0] w1;
    string tag;
    @(negedge clk);
    busActive = act; busAddr = addr; busData = data;
    busWait = wt; busByteEn = en; busAddrErr = err;
    if (err)             begin w1 = 32'h22222222; tag = "R9"; end
    else if (wt)         begin w1 = 32'h00000000; tag = "R7"; end
    else if (en == 4'h0) begin w1 = 32'h11111111; tag = "R8"; end
    else                 begin w1 = data;         tag = "R6"; end
    expValidQ.push_back(act);
    expW0Q.push_back({1'b0, wt | (en == 4'h0), addr[31:2]});
    expW1Q.push_back(w1);
    expTagQ.push_back(tag);
  endtask

  // Monitor: sample just after each rising edge, pop one expectation per cycle
  always @(posedge clk) begin
    #1;
    if (monitorOn && expValidQ.size() > 0) begin
      logic        ev;
      logic [31:0] e0;
      logic [31:0] e1;
      string       tg;
      ev = expValidQ.pop_front();
      e0 = expW0Q.pop_front();
      e1 = expW1Q.pop_front();
      tg = expTagQ.pop_front();
      check(recValid === ev, ev ? "R1 valid" : "R2 valid", {31'b0, recValid}, {31'b0, ev});
      if (ev) begin
        check(recWord0[31] === 1'b0, "R3 format", {31'b0, recWord0[31]}, 32'h0);
        check(recWord0[29:0] === e0[29:0], "R4 addr", recWord0, e0);
        check(recWord0[30] === e0[30], "R5 wait flag", {31'b0, recWord0[30]}, {31'b0, e0[30]});
        check(recWord1 === e1, tg, recWord1, e1);
      end
    end
  end

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rstN = 1'b0; busActive = 1'b1; busAddr = 32'hFFFF_FFFC; busData = 32'hDEAD_BEEF;
    busWait = 1'b0; busByteEn = 4'hF; busAddrErr = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check(recValid === 1'b0, "R10 in reset", {31'b0, recValid}, 32'h0);
    end
    busActive = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(recValid === 1'b0, "R10 after reset", {31'b0, recValid}, 32'h0);
    monitorOn = 1'b1;
    // plain transfers with varied lanes (R6, R4)
    drive(1, 32'h1000_0004, 32'hA5A5_0001, 0, 4'hF, 0);
    drive(1, 32'hFFFF_FFFF, 32'h0000_0002, 0, 4'h1, 0);
    drive(1, 32'h0000_0003, 32'h8000_0000, 0, 4'h8, 0);
    // idle cycles with noise on the other inputs (R2)
    drive(0, 32'h1234_5678, 32'h2222_2222, 1, 4'h0, 1);
    drive(0, 32'h0, 32'h0, 0, 4'hF, 0);
    // wait state (R7, R5)
    drive(1, 32'h2000_0010, 32'hCAFE_F00D, 1, 4'hF, 0);
    // all lanes disabled (R8, R5)
    drive(1, 32'h2000_0014, 32'hCAFE_F00D, 0, 4'h0, 0);
    // wait combined with no lanes: wait marker wins (R7)
    drive(1, 32'h2000_0018, 32'h5555_5555, 1, 4'h0, 0);
    // error alone and overlapping wait/no-lane (R9)
    drive(1, 32'h3000_0000, 32'h1357_9BDF, 0, 4'hF, 1);
    drive(1, 32'h3000_0004, 32'h1357_9BDF, 1, 4'hF, 1);
    drive(1, 32'h3000_0008, 32'h1357_9BDF, 0, 4'h0, 1);
    drive(1, 32'h3000_000C, 32'h1357_9BDF, 1, 4'h0, 1);
    // back-to-back after error, then idle
    drive(1, 32'h4000_0000, 32'h0F0F_0F0F, 0, 4'h3, 0);
    drive(0, 32'h0, 32'h0, 0, 4'h0, 0);
    // sweep of lane patterns and conditions
    for (int i = 0; i < 64; i++) begin
      drive(i[0] | i[1], {i[7:0], 24'h00_00_00} ^ 32'h0ABC_DEF0, {4{i[7:0]}} ^ 32'h9E37_79B9,
            i[2], i[3:0] & {4{i[4]}}, i[5]);
    end
    drive(0, 32'h0, 32'h0, 0, 4'h0, 0);
    repeat (3) @(negedge clk);
    check(expValidQ.size() == 0, "R1 all records seen", expValidQ.size(), 32'h0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule